// File: doc/BRIEF.md
# Destructive-Read Erasable Memory Cycle Controller

This block runs the memory cycle of a word-organized erasable store that loses a word whenever it is read. Each access goes through a fixed sequence. The word is selected first. It is then cleared while its old contents are sensed, and the sensed parity is checked. Last, the word is rewritten by driving every bit toward 1 and inhibiting the bits that must stay 0. A read-only access puts back the value it just sensed. A write access uses the same cycle but puts back the new data. The address chosen at selection is held until the rewrite finishes, so no second address load takes place later in the cycle.

Each stored word holds 15 data bits and one odd-parity bit, which sits just above the highest data bit. A fault input marks the inhibit line of one physical bit position as broken. That position is then forced to 1 on every rewrite. A repair-mode input swaps the logical data bit that sits on the broken position with the parity slot, on both write and read, and blocks the parity alarm. This gives up parity checking so that all data bits keep working.

Requests use a valid/ready handshake. `req_ready` is high only while the controller is idle. A requester that holds `req_valid` with stable fields while `req_ready` is low has its request taken on the first idle cycle. Completion is a one-cycle `done` pulse with no back-pressure. `rd_data` and `par_alarm` stay valid from that pulse until the next access reaches its check step.

Top module: `erasable_cycle_ctrl`

## Requirements
- R1: After reset the controller is idle, with `req_ready`=1, `busy`=0, `done`=0 and `par_alarm`=0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `busy` is then high for exactly 4 cycles and `done` follows for exactly 1 cycle. `req_ready` is 0 from the accepting edge until `done` has dropped, and a request held pending during that time is taken afterwards.
- R3: A read (`req_write`=0) returns on `rd_data` the data last stored at that address and restores it, so repeated reads return the same value.
- R4: A write replaces the whole word. Bits that were 1 and are written 0 read back 0, because every access clears the word before rewriting it.
- R5: Stored parity is odd, in physical bit 15: it is 1 when the 15 data bits hold an even count of ones. When repair mode is off, `par_alarm` is 1 at `done` exactly when the sensed parity bit differs from the parity recomputed from the sensed data.
- R6: With `fault_en`=1, physical bit position `fault_bit` (0..14) is stored as 1 on every rewrite whatever value was intended. The read phase never uses inhibit, so a read returns what is physically held.
- R7: With `repair_mode`=1, logical data bit `fault_bit` is stored in physical slot 15 and the parity bit in physical slot `fault_bit`. Reads undo this swap, and `par_alarm` stays 0.
- R8: All 2048 addresses hold independent words. Addresses 0 and 2047 both work.
- R9: `req_write`, `req_addr`, `req_wdata`, `fault_en`, `fault_bit` and `repair_mode` are sampled at the accepting edge and are held for that whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write `req_wdata`, 0 = read and restore |
| req_addr | input | 11 | Word address |
| req_wdata | input | 15 | Write data |
| rd_data | output | 15 | Data sensed by the last access |
| busy | output | 1 | Access in progress (select through rewrite) |
| done | output | 1 | One-cycle completion pulse |
| par_alarm | output | 1 | Parity mismatch seen by the last access |
| fault_en | input | 1 | Marks one inhibit line as broken |
| fault_bit | input | 4 | Physical position of the broken inhibit (0..14) |
| repair_mode | input | 1 | Swap the faulty bit with parity, block the alarm |

## Verification
The bench first writes ones into a word and then writes zero over it. A design that only set bits during the rewrite, without clearing them first, would keep the stale ones. It reads the same word twice to catch a design that forgets to restore after the destructive read. It writes zero while a fault is present, which must later raise an alarm and return the forced 1. It also reads a repaired word with repair mode switched off, which shows whether the swap really moves data into the parity slot and whether the alarm is blocked only in repair mode. Handshake tests count busy and done cycles and hold a second request pending, to catch a design that drops the pending request or takes it while busy.

// File: rtl/erc_pkg.sv
package erc_pkg;
  typedef enum logic [2:0] {
    CS_IDLE,
    CS_SELECT,
    CS_READ_CLEAR,
    CS_CHECK,
    CS_REWRITE,
    CS_DONE
  } cyc_state_t;
endpackage

// File: rtl/erc_seq.sv
module erc_seq
  import erc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output cyc_state_t state,
  output logic       accept,
  output logic       req_ready,
  output logic       busy,
  output logic       done
);
  cyc_state_t nxt;

  assign req_ready = (state == CS_IDLE);
  assign accept    = req_valid && req_ready;
  assign busy      = (state == CS_SELECT) || (state == CS_READ_CLEAR) ||
                     (state == CS_CHECK)  || (state == CS_REWRITE);
  assign done      = (state == CS_DONE);

  always_comb begin
    nxt = state;
    unique case (state)
      CS_IDLE:       if (accept) nxt = CS_SELECT;
      CS_SELECT:     nxt = CS_READ_CLEAR;
      CS_READ_CLEAR: nxt = CS_CHECK;
      CS_CHECK:      nxt = CS_REWRITE;
      CS_REWRITE:    nxt = CS_DONE;
      CS_DONE:       nxt = CS_IDLE;
      default:       nxt = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= CS_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/erc_lanes.sv
module erc_lanes #(
  parameter int DATA_W = 15,
  parameter int SEL_W  = 4,
  localparam int WORD_W = DATA_W + 1
) (
  input  logic              repair,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] enc_data,
  output logic [WORD_W-1:0] enc_word,
  input  logic [WORD_W-1:0] dec_word,
  output logic [DATA_W-1:0] dec_data,
  output logic              dec_par
);
  logic par_new;
  assign par_new = ~^enc_data;

  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    logic hit;
    assign hit         = repair && (sel == SEL_W'(i));
    assign enc_word[i] = hit ? par_new : enc_data[i];
    assign dec_data[i] = hit ? dec_word[DATA_W] : dec_word[i];
  end

  assign enc_word[DATA_W] = repair ? enc_data[sel] : par_new;
  assign dec_par          = repair ? dec_word[sel] : dec_word[DATA_W];
endmodule

// File: rtl/erc_array.sv
module erc_array #(
  parameter int ADDR_W = 11,
  parameter int WORD_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic              clr_en,
  input  logic              set_en,
  input  logic [WORD_W-1:0] set_word,
  output logic [WORD_W-1:0] sense_word
);
  logic [WORD_W-1:0] cells [DEPTH];

  assign sense_word = cells[addr];

  always_ff @(posedge clk) begin
    if (clr_en)      cells[addr] <= '0;
    else if (set_en) cells[addr] <= set_word;
  end
endmodule

// File: rtl/erasable_cycle_ctrl.sv
module erasable_cycle_ctrl
  import erc_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 15,
  localparam int WORD_W = DATA_W + 1,
  localparam int SEL_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              par_alarm,
  input  logic              fault_en,
  input  logic [SEL_W-1:0]  fault_bit,
  input  logic              repair_mode
);
  cyc_state_t        state;
  logic              accept;
  logic [ADDR_W-1:0] sel_addr;
  logic              wr_q, rep_q, fen_q;
  logic [SEL_W-1:0]  fsel_q;
  logic [DATA_W-1:0] wdata_q;
  logic [WORD_W-1:0] sense_q, array_out, phys_new, stuck, inhibit;
  logic [DATA_W-1:0] dec_data, target;
  logic              dec_par;

  erc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .state(state),
    .accept(accept), .req_ready(req_ready), .busy(busy), .done(done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_addr <= '0;
      wr_q     <= 1'b0;
      rep_q    <= 1'b0;
      fen_q    <= 1'b0;
      fsel_q   <= '0;
      wdata_q  <= '0;
    end else if (accept) begin
      sel_addr <= req_addr;
      wr_q     <= req_write;
      rep_q    <= repair_mode;
      fen_q    <= fault_en;
      fsel_q   <= fault_bit;
      wdata_q  <= req_wdata;
    end
  end

  assign target = wr_q ? wdata_q : rd_data;

  erc_lanes #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_lanes (
    .repair(rep_q), .sel(fsel_q), .enc_data(target), .enc_word(phys_new),
    .dec_word(sense_q), .dec_data(dec_data), .dec_par(dec_par)
  );

  assign stuck   = fen_q ? (WORD_W'(1) << fsel_q) : '0;
  assign inhibit = ~phys_new & ~stuck;

  erc_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
    .clk(clk), .addr(sel_addr),
    .clr_en(state == CS_READ_CLEAR),
    .set_en(state == CS_REWRITE),
    .set_word(~inhibit),
    .sense_word(array_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sense_q   <= '0;
      rd_data   <= '0;
      par_alarm <= 1'b0;
    end else begin
      if (accept) par_alarm <= 1'b0;
      if (state == CS_READ_CLEAR) sense_q <= array_out;
      if (state == CS_CHECK) begin
        rd_data   <= dec_data;
        par_alarm <= !rep_q && (dec_par != ~^dec_data);
      end
    end
  end
endmodule

// File: rtl/erasable_cycle_ctrl_chk.sv
module erasable_cycle_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic done,
  input logic par_alarm,
  input logic rep_q
);
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);  // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R2
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));  // R2
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);  // R2
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> req_ready);  // R1
  AST_REPAIR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rep_q |-> !par_alarm);  // R7
endmodule

bind erasable_cycle_ctrl erasable_cycle_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .done(done), .par_alarm(par_alarm), .rep_q(rep_q)
);

// File: tb/tb_erasable_cycle_ctrl.sv
module tb_erasable_cycle_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [10:0] req_addr = '0;
  logic [14:0] req_wdata = '0;
  logic        fault_en = 1'b0, repair_mode = 1'b0;
  logic [3:0]  fault_bit = '0;
  logic        req_ready, busy, done, par_alarm;
  logic [14:0] rd_data;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  erasable_cycle_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .busy(busy), .done(done), .par_alarm(par_alarm),
    .fault_en(fault_en), .fault_bit(fault_bit), .repair_mode(repair_mode)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // fields: chk, wr, addr, wdata, fen, fbit, rep, exp_data, exp_alarm
  localparam int NV = 19;
  localparam logic [49:0] VEC [NV] = '{
    {1'b0, 1'b1, 11'd5,    15'h1234, 1'b0, 4'd0, 1'b0, 15'h0000, 1'b0},
    {1'b1, 1'b0, 11'd5,    15'h0000, 1'b0, 4'd0, 1'b0, 15'h1234, 1'b0}, // R3
    {1'b1, 1'b0, 11'd5,    15'h0000, 1'b0, 4'd0, 1'b0, 15'h1234, 1'b0}, // R3 restore
    {1'b0, 1'b1, 11'd2047, 15'h7FFF, 1'b0, 4'd0, 1'b0, 15'h0000, 1'b0},
    {1'b0, 1'b1, 11'd0,    15'h0000, 1'b0, 4'd0, 1'b0, 15'h0000, 1'b0},
    {1'b1, 1'b0, 11'd2047, 15'h0000, 1'b0, 4'd0, 1'b0, 15'h7FFF, 1'b0}, // R8
    {1'b1, 1'b0, 11'd0,    15'h0000, 1'b0, 4'd0, 1'b0, 15'h0000, 1'b0}, // R8 R5
    {1'b0, 1'b1, 11'd5,    15'h0000, 1'b0, 4'd0, 1'b0, 15'h0000, 1'b0},
    {1'b1, 1'b0, 11'd5,    15'h0000, 1'b0, 4'd0, 1'b0, 15'h0000, 1'b0}, // R4
    {1'b0, 1'b1, 11'd9,    15'h0000, 1'b1, 4'd3, 1'b0, 15'h0000, 1'b0},
    {1'b1, 1'b0, 11'd9,    15'h0000, 1'b1, 4'd3, 1'b0, 15'h0008, 1'b1}, // R6 R5
    {1'b1, 1'b0, 11'd9,    15'h0000, 1'b1, 4'd3, 1'b0, 15'h0008, 1'b0}, // R6
    {1'b0, 1'b1, 11'd11,   15'h0000, 1'b1, 4'd3, 1'b1, 15'h0000, 1'b0},
    {1'b1, 1'b0, 11'd11,   15'h0000, 1'b1, 4'd3, 1'b1, 15'h0000, 1'b0}, // R7
    {1'b0, 1'b1, 11'd12,   15'h0008, 1'b1, 4'd3, 1'b1, 15'h0000, 1'b0},
    {1'b1, 1'b0, 11'd12,   15'h0000, 1'b1, 4'd3, 1'b1, 15'h0008, 1'b0}, // R7 blocked
    {1'b1, 1'b0, 11'd12,   15'h0000, 1'b1, 4'd3, 1'b0, 15'h0008, 1'b1}, // R7 swap seen raw
    {1'b0, 1'b1, 11'd13,   15'h2AAA, 1'b1, 4'd3, 1'b1, 15'h0000, 1'b0},
    {1'b1, 1'b0, 11'd13,   15'h0000, 1'b1, 4'd3, 1'b1, 15'h2AAA, 1'b0}  // R7
  };

  task automatic access(input bit wr, input logic [10:0] a, input logic [14:0] d,
                        input bit fen, input logic [3:0] fb, input bit rep);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    fault_en = fen; fault_bit = fb; repair_mode = rep;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    // R9: change inputs mid-access; the access must use the sampled ones
    req_write = ~wr; req_wdata = ~d; repair_mode = ~rep; fault_bit = fb + 4'd1;
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req_ready && !busy && !done && !par_alarm, "R1 reset",
          {busy, done, par_alarm, req_ready}, 4'b0001);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [49:0] v;
      v = VEC[i];
      access(v[48], v[47:37], v[36:22], v[21], v[20:17], v[16]);
      if (v[49]) begin
        check(rd_data == v[15:1], $sformatf("R3/R4/R6/R7/R8 data vec%0d", i),
              rd_data, v[15:1]);
        check(par_alarm == v[0], $sformatf("R5/R7 alarm vec%0d", i),
              par_alarm, v[0]);
      end
    end

    // R2: cycle timing and back-pressure
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 11'd5;
    fault_en = 1'b0; repair_mode = 1'b0;
    check(req_ready, "R2 ready when idle", req_ready, 1);
    for (int c = 1; c <= 4; c++) begin
      @(negedge clk);
      check(busy && !done && !req_ready, $sformatf("R2 busy cycle %0d", c),
            {busy, done, req_ready}, 3'b100);
    end
    @(negedge clk);
    check(!busy && done && !req_ready, "R2 done pulse", {busy, done, req_ready}, 3'b010);
    req_addr = 11'd2047;  // pending request, held while not ready
    @(negedge clk);
    check(!done && req_ready, "R2 done single cycle, ready again", {done, req_ready}, 2'b01);
    @(negedge clk);
    req_valid = 1'b0;
    check(busy, "R2 pending request taken", busy, 1);
    while (!done) @(negedge clk);
    check(rd_data == 15'h7FFF, "R2 pending request data", rd_data, 15'h7FFF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule